// File: doc/BRIEF.md
# Suspend Modulation Throttle Controller

This block slows a processor by periodically pulling an active-low suspend line. While the line is low the processor sits idle. While it is high the processor runs. The block alternates a suspended phase and a running phase, and each phase lasts a programmed number of base ticks. The effective throughput is therefore running / (running + suspended) of full speed. A prescaler turns the system clock into the base tick, which is nominally 32 microseconds. It also derives a coarser millisecond unit from that tick.

Software programs the block through a byte-wide write port. It sets the running and suspended tick counts, a modulation enable, and a power-management byte. Two speedup timer lengths complete the register set. When speedup is enabled, an interrupt event or a video-activity event loads a timer. The suspend line is then held released until that timer has counted down in millisecond units. A further event restarts the timer.

Top module: `susp_throttle`

## Requirements
- R1: After reset all registers are zero, modulation is disabled and `susp_n` is 1.
- R2: Modulation runs only while bit 0 of the configuration register (address 0x96) is 1. While that bit is 0, `susp_n` is 1 from the next clock on.
- R3: With modulation enabled, `susp_n` alternates. It is 0 for ON-count base ticks, where ON is the register at 0x95. It is 1 for OFF-count base ticks, where OFF is the register at 0x94. One base tick is `TICK_DIV` clock cycles.
- R4: A new ON or OFF value does not alter a phase already in progress. Counts are taken only when a phase ends.
- R5: A phase whose count is zero is skipped. ON = 0 keeps `susp_n` at 1. OFF = 0 with ON > 0 keeps it at 0. Both zero keeps it at 1.
- R6: Register addresses are as follows: 0x80 is power management, 0x8C is the interrupt speedup length, 0x8D is the video speedup length, 0x94 is OFF, 0x95 is ON and 0x96 is configuration. A write takes effect at the clock edge where `wr_en` is 1.
- R7: If power-management bits 0 (global) and 3 (interrupt speedup) are both 1, a pulse on `irq_evt` loads the interrupt timer from 0x8C. `susp_n` is 1 while any speedup timer is nonzero.
- R8: If power-management bits 0 and 4 (video speedup) are both 1, a pulse on `vid_evt` loads the video timer from 0x8D with the same effect.
- R9: An event arriving while its timer is running reloads the full length.
- R10: An event whose enable bit or the global bit is 0 has no effect on `susp_n`.
- R11: Speedup timers decrement once per millisecond unit, which is `MS_TICKS` base ticks. The modulation itself keeps running while a timer forces `susp_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| irq_evt | input | 1 | Interrupt activity event, one cycle |
| vid_evt | input | 1 | Video activity event, one cycle |
| susp_n | output | 1 | Active-low suspend request to the processor |

## Verification
A register write lands at the next rising edge. A disable releases `susp_n` one cycle later. An enabled speedup event holds `susp_n` high from the edge after the pulse. Phase changes happen only on base-tick edges, and the tick phase is not aligned with the stimulus. For that reason the duty cycle is checked as run lengths of `susp_n`, sampled on falling clock edges and measured between consecutive transitions after the first full period. Speedup checks sample a window that is shorter than the minimum guaranteed timer life. Checks for ignored events look for a low phase within one modulation period.

// File: rtl/thr_pkg.sv
package thr_pkg;

    localparam logic [7:0] A_PM      = 8'h80;
    localparam logic [7:0] A_IRQ_LEN = 8'h8C;
    localparam logic [7:0] A_VID_LEN = 8'h8D;
    localparam logic [7:0] A_RUN_CNT = 8'h94;
    localparam logic [7:0] A_SUS_CNT = 8'h95;
    localparam logic [7:0] A_CFG     = 8'h96;

    localparam int NUM_SPD = 2;
    localparam int SPD_IRQ = 0;
    localparam int SPD_VID = 1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_SUSP = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e     ph;
        logic [7:0] rem;
    } step_t;

    typedef struct packed {
        logic gpm;
        logic irq_spd;
        logic vid_spd;
    } pm_t;

    // Choose the phase that follows a boundary; zero-length phases are skipped.
    function automatic step_t next_step(input logic to_susp,
                                        input logic [7:0] run_c,
                                        input logic [7:0] sus_c);
        step_t s;
        s.ph  = PH_IDLE;
        s.rem = '0;
        if (to_susp) begin
            if (sus_c != 8'd0) begin
                s.ph = PH_SUSP; s.rem = sus_c;
            end else if (run_c != 8'd0) begin
                s.ph = PH_RUN;  s.rem = run_c;
            end
        end else begin
            if (run_c != 8'd0) begin
                s.ph = PH_RUN;  s.rem = run_c;
            end else if (sus_c != 8'd0) begin
                s.ph = PH_SUSP; s.rem = sus_c;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/thr_prescaler.sv
module thr_prescaler #(
    parameter int TICK_DIV = 1600,
    parameter int MS_TICKS = 31
) (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic ms
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int MS_W  = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
    localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(MS_TICKS - 1);

    logic [PRE_W-1:0] pre_q;
    logic [MS_W-1:0]  ms_q;

    assign tick = (pre_q == PRE_LAST);
    assign ms   = tick && (ms_q == MS_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) ms_q <= (ms_q == MS_LAST) ? '0 : ms_q + 1'b1;
        end
    end
endmodule

// File: rtl/thr_spd_timer.sv
module thr_spd_timer (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig,
    input  logic [7:0] load,
    input  logic       ms,
    output logic [7:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)                      cnt <= '0;
        else if (trig)                cnt <= load;
        else if (ms && cnt != 8'd0)   cnt <= cnt - 8'd1;
    end
endmodule

// File: rtl/thr_modulator.sv
module thr_modulator
    import thr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  logic [7:0] run_cnt,
    input  logic [7:0] sus_cnt,
    output logic       in_susp,
    output logic       active
);
    phase_e     ph_q;
    logic [7:0] rem_q;
    step_t      nxt;

    always_comb begin
        nxt.ph  = ph_q;
        nxt.rem = rem_q;
        if (!en) begin
            nxt.ph  = PH_IDLE;
            nxt.rem = '0;
        end else begin
            case (ph_q)
                PH_IDLE: nxt = next_step(1'b0, run_cnt, sus_cnt);
                PH_RUN: if (tick) begin
                    if (rem_q <= 8'd1) nxt = next_step(1'b1, run_cnt, sus_cnt);
                    else               nxt.rem = rem_q - 8'd1;
                end
                PH_SUSP: if (tick) begin
                    if (rem_q <= 8'd1) nxt = next_step(1'b0, run_cnt, sus_cnt);
                    else               nxt.rem = rem_q - 8'd1;
                end
                default: begin
                    nxt.ph  = PH_IDLE;
                    nxt.rem = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            rem_q <= '0;
        end else begin
            ph_q  <= nxt.ph;
            rem_q <= nxt.rem;
        end
    end

    assign in_susp = (ph_q == PH_SUSP);
    assign active  = (ph_q != PH_IDLE);
endmodule

// File: rtl/susp_throttle.sv
module susp_throttle
    import thr_pkg::*;
#(
    parameter int TICK_DIV = 1600,
    parameter int MS_TICKS = 31
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       irq_evt,
    input  logic       vid_evt,
    output logic       susp_n
);
    logic [7:0] run_cnt_q, sus_cnt_q, irq_len_q, vid_len_q;
    logic       mod_en_q;
    pm_t        pm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt_q <= '0;
            sus_cnt_q <= '0;
            irq_len_q <= '0;
            vid_len_q <= '0;
            mod_en_q  <= 1'b0;
            pm_q      <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_RUN_CNT: run_cnt_q <= wr_data;
                A_SUS_CNT: sus_cnt_q <= wr_data;
                A_IRQ_LEN: irq_len_q <= wr_data;
                A_VID_LEN: vid_len_q <= wr_data;
                A_CFG:     mod_en_q  <= wr_data[0];
                A_PM: begin
                    pm_q.gpm     <= wr_data[0];
                    pm_q.irq_spd <= wr_data[3];
                    pm_q.vid_spd <= wr_data[4];
                end
                default: ;
            endcase
        end
    end

    logic tick, ms;

    thr_prescaler #(.TICK_DIV(TICK_DIV), .MS_TICKS(MS_TICKS)) u_pre (
        .clk(clk), .rst(rst), .tick(tick), .ms(ms)
    );

    logic [NUM_SPD-1:0] spd_trig;
    logic [NUM_SPD-1:0] spd_busy;
    logic [7:0]         spd_load [NUM_SPD];
    logic [7:0]         spd_cnt  [NUM_SPD];

    assign spd_trig[SPD_IRQ] = irq_evt && pm_q.gpm && pm_q.irq_spd;
    assign spd_trig[SPD_VID] = vid_evt && pm_q.gpm && pm_q.vid_spd;
    assign spd_load[SPD_IRQ] = irq_len_q;
    assign spd_load[SPD_VID] = vid_len_q;

    for (genvar i = 0; i < NUM_SPD; i++) begin : g_spd
        thr_spd_timer u_tmr (
            .clk(clk), .rst(rst), .trig(spd_trig[i]),
            .load(spd_load[i]), .ms(ms), .cnt(spd_cnt[i])
        );
        assign spd_busy[i] = (spd_cnt[i] != 8'd0);
    end

    logic in_susp, active;

    thr_modulator u_mod (
        .clk(clk), .rst(rst), .en(mod_en_q), .tick(tick),
        .run_cnt(run_cnt_q), .sus_cnt(sus_cnt_q),
        .in_susp(in_susp), .active(active)
    );

    assign susp_n = !(in_susp && (spd_busy == '0));
endmodule

// File: rtl/thr_checker.sv
module thr_checker (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       tick,
    input logic       ms,
    input logic       active,
    input logic       in_susp,
    input logic       susp_n,
    input logic       irq_trig,
    input logic [7:0] irq_load,
    input logic [7:0] irq_cnt,
    input logic [7:0] vid_cnt
);
    AST_MS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        ms |-> tick);                                           // R11
    AST_DISABLED_HIGH: assert property (@(posedge clk) disable iff (rst)
        !en |=> susp_n);                                        // R2
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (active && en && !tick) |=> $stable(in_susp));          // R4
    AST_SPD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (irq_cnt != 8'd0 || vid_cnt != 8'd0) |-> susp_n);       // R7
    AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
        irq_trig |=> (irq_cnt == $past(irq_load)));             // R9
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !active |-> susp_n);                                    // R5
endmodule

bind susp_throttle thr_checker u_chk (
    .clk(clk), .rst(rst), .en(mod_en_q), .tick(tick), .ms(ms),
    .active(active), .in_susp(in_susp), .susp_n(susp_n),
    .irq_trig(spd_trig[0]), .irq_load(spd_load[0]),
    .irq_cnt(spd_cnt[0]), .vid_cnt(spd_cnt[1])
);

// File: tb/susp_throttle_tb.sv
module susp_throttle_tb;
    localparam int D  = 4;
    localparam int MT = 4;

    logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, irq_evt = 1'b0, vid_evt = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0;
    logic susp_n;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    susp_throttle #(.TICK_DIV(D), .MS_TICKS(MT)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq_evt(irq_evt), .vid_evt(vid_evt), .susp_n(susp_n)
    );

    // {OFF (running ticks), ON (suspended ticks)}
    localparam logic [15:0] VEC [0:3] = '{16'h0302, 16'h0101, 16'h0504, 16'h0207};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_fall();
        logic prev;
        @(negedge clk); prev = susp_n;
        forever begin
            @(negedge clk);
            if (prev === 1'b1 && susp_n === 1'b0) break;
            prev = susp_n;
        end
    endtask

    task automatic count_run(input logic lvl, output int n);
        n = 1;
        forever begin
            @(negedge clk);
            if (susp_n === lvl && n < 4000) n++;
            else break;
        end
    endtask

    task automatic hold_level(input logic lvl, input int cyc, input string req);
        int bad = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (susp_n !== lvl) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic sees_low(input int cyc, input string req);
        int seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (susp_n === 1'b0) seen = 1;
        end
        check(seen == 1, req, seen, 1);
    endtask

    task automatic pulse_irq();
        @(negedge clk); irq_evt = 1'b1;
        @(negedge clk); irq_evt = 1'b0;
    endtask

    task automatic pulse_vid();
        @(negedge clk); vid_evt = 1'b1;
        @(negedge clk); vid_evt = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int nl, nh;
        repeat (3) @(negedge clk);
        check(susp_n === 1'b1, "R1 susp_n during reset", susp_n, 1);
        rst = 1'b0;
        hold_level(1'b1, 20, "R1 idle after reset");

        // counts programmed but enable clear
        wr(8'h94, 8'd2); wr(8'h95, 8'd3);
        hold_level(1'b1, 40, "R2 disabled keeps susp_n high");

        wr(8'h96, 8'h01);
        for (int v = 0; v < 4; v++) begin
            wr(8'h94, VEC[v][15:8]);
            wr(8'h95, VEC[v][7:0]);
            wait_fall(); wait_fall();
            count_run(1'b0, nl);
            count_run(1'b1, nh);
            check(nl == int'(VEC[v][7:0]) * D, "R3 low run length", nl, VEC[v][7:0] * D);
            check(nh == int'(VEC[v][15:8]) * D, "R3 high run length", nh, VEC[v][15:8] * D);
        end

        // R4: change ON mid-phase with OFF=3 ON=2
        wr(8'h94, 8'd3); wr(8'h95, 8'd2);
        wait_fall(); wait_fall();
        fork
            count_run(1'b0, nl);
            begin @(negedge clk); wr(8'h95, 8'd6); end
        join
        count_run(1'b1, nh);
        check(nl == 2 * D, "R4 phase in progress unchanged", nl, 2 * D);
        check(nh == 3 * D, "R4 running phase", nh, 3 * D);
        count_run(1'b0, nl);
        check(nl == 6 * D, "R4 new ON after boundary", nl, 6 * D);

        // R2: disable releases
        wr(8'h94, 8'd2); wr(8'h95, 8'd3);
        wait_fall();
        wr(8'h96, 8'h00);
        hold_level(1'b1, 30, "R2 disable mid suspend");
        wr(8'h96, 8'h01);

        // R5 zero phases
        wr(8'h95, 8'd0); wr(8'h94, 8'd3);
        repeat (40) @(negedge clk);
        hold_level(1'b1, 40, "R5 ON zero stays high");
        wr(8'h94, 8'd0); wr(8'h95, 8'd3);
        repeat (40) @(negedge clk);
        hold_level(1'b0, 40, "R5 OFF zero stays low");
        wr(8'h95, 8'd0);
        repeat (20) @(negedge clk);
        hold_level(1'b1, 40, "R5 both zero stays high");

        // speedup: OFF=2 ON=3, period 20 cycles
        wr(8'h94, 8'd2); wr(8'h95, 8'd3);
        wr(8'h8C, 8'd2); wr(8'h8D, 8'd2);
        wr(8'h80, 8'h09);
        wait_fall();
        pulse_irq();
        hold_level(1'b1, 16, "R7 irq speedup holds high");
        sees_low(60, "R11 modulation resumes after timer");

        wait_fall();
        pulse_irq(); repeat (12) @(negedge clk);
        pulse_irq(); repeat (12) @(negedge clk);
        pulse_irq();
        hold_level(1'b1, 16, "R9 retrigger extends speedup");

        repeat (60) @(negedge clk);
        wait_fall();
        pulse_vid();
        sees_low(24, "R10 video ignored without enable");

        wr(8'h80, 8'h19);
        wait_fall();
        pulse_vid();
        hold_level(1'b1, 16, "R8 video speedup holds high");

        wr(8'h80, 8'h18);
        repeat (60) @(negedge clk);
        wait_fall();
        pulse_irq();
        sees_low(24, "R10 irq ignored without global enable");

        // R6: unmapped address leaves counts alone
        wr(8'h97, 8'd9);
        wait_fall(); wait_fall();
        count_run(1'b0, nl);
        check(nl == 3 * D, "R6 unmapped write ignored", nl, 3 * D);

        summary();
        $finish;
    end
endmodule